// File: doc/BRIEF.md
# Fast Ethernet PHY management register model

This block models the management register file of a simple 10/100 Ethernet PHY as seen from a station manager. A requester presents a PHY address, a 5-bit register index, a read/write flag and 16-bit write data on a parallel request port for one cycle. Reads answer on a registered response port in the next cycle. The serial management framing is handled elsewhere. This block only holds and serves the registers.

The block holds a control word, an ability advertisement word, a status word and a link-partner ability word. It also answers two fixed identifier words. A `link_up` input is tracked every clock, so the status and partner words follow the live link without any management traffic. Setting the top bit of the control word on a write reloads every register to its power-on value. The link-dependent bits are then taken again from the current link. Requests to any PHY address other than the configured one are treated as if no device were present.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, with `link_up` low, reads return control 0x3100 (index 0), status 0x7848 (index 1), advertisement 0x01E1 (index 4) and partner 0x0080 (index 5). While reset is held, `rsp_valid` and `rsp_rdata` are 0.
- R2: `rsp_valid` is high in exactly the cycle after a read request. `rsp_rdata` carries the read word in that cycle and is 0 in every cycle without a response. Writes produce no response.
- R3: A read whose `req_phy` differs from the parameter `PHY_ADDR` returns 0xFFFF. A write to such an address changes no register.
- R4: One clock after `link_up` is sampled high, status bits 2 (link) and 5 (negotiation done) are set, giving 0x786C. The partner word becomes 0x01E1.
- R5: One clock after `link_up` is sampled low, status bits 2 and 5 are clear (0x7848) and the partner word is 0x0080.
- R6: A write to index 0 with bit 15 clear stores the written word unchanged.
- R7: A write to index 0 with bit 15 set restores control to 0x3100 and advertisement to 0x01E1. Status and partner take the values for the current `link_up`.
- R8: Index 4 (advertisement) stores any written word.
- R9: Writes to indices 1, 2, 3, 5 and 6 are dropped; later reads return the same words as before the write.
- R10: Index 2 reads the parameter `ID_HI` and index 3 reads `ID_LO`.
- R11: Index 6, indices 16 to 20, and every other index not listed above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | PHY_ADDR_W | Target PHY address |
| req_reg | input | 5 | Register index |
| req_wdata | input | 16 | Write data |
| link_up | input | 1 | Live link indication |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 16 | Read response word |

## Verification
Every stored word can be read directly, so a wrong control or advertisement value shows on `rsp_rdata` one cycle after the next read of that index. A stale link-derived bit shows on the first status or partner read issued one clock after `link_up` changes. A wrong decode of an address or an index shows in the response of that same request. The bench keeps its own model of the register contents and of the sampled link. It checks the response port against that model on every clock, and so catches a wrong value at the first read that exposes it.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;

    // register indices whose position is fixed by the management protocol
    localparam logic [IDX_W-1:0] IDX_CTRL    = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ID_HI   = 5'd2;
    localparam logic [IDX_W-1:0] IDX_ID_LO   = 5'd3;
    localparam logic [IDX_W-1:0] IDX_ADV     = 5'd4;
    localparam logic [IDX_W-1:0] IDX_PARTNER = 5'd5;

    // control word bits
    localparam int CTRL_RST_BIT   = 15;
    localparam int CTRL_SPD_BIT   = 13;
    localparam int CTRL_NEG_BIT   = 12;
    localparam int CTRL_DUPLX_BIT = 8;

    // status word bits
    localparam int ST_T100_FD_BIT = 14;
    localparam int ST_T100_HD_BIT = 13;
    localparam int ST_T10_FD_BIT  = 12;
    localparam int ST_T10_HD_BIT  = 11;
    localparam int ST_PRE_SUP_BIT = 6;
    localparam int ST_NEG_OK_BIT  = 5;
    localparam int ST_NEG_CAP_BIT = 3;
    localparam int ST_LINK_BIT    = 2;

    // ability word bits (advertisement and partner share the layout)
    localparam int AB_T100_FD_BIT = 8;
    localparam int AB_T100_BIT    = 7;
    localparam int AB_T10_FD_BIT  = 6;
    localparam int AB_T10_BIT     = 5;
    localparam int AB_SEL_BIT     = 0;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    localparam logic [DATA_W-1:0] CTRL_INIT =
        (ONE << CTRL_SPD_BIT) | (ONE << CTRL_NEG_BIT) | (ONE << CTRL_DUPLX_BIT);

    localparam logic [DATA_W-1:0] STATUS_BASE =
        (ONE << ST_T100_FD_BIT) | (ONE << ST_T100_HD_BIT) |
        (ONE << ST_T10_FD_BIT)  | (ONE << ST_T10_HD_BIT)  |
        (ONE << ST_PRE_SUP_BIT) | (ONE << ST_NEG_CAP_BIT);

    localparam logic [DATA_W-1:0] STATUS_LINK_BITS =
        (ONE << ST_LINK_BIT) | (ONE << ST_NEG_OK_BIT);

    localparam logic [DATA_W-1:0] ADV_INIT =
        (ONE << AB_T100_FD_BIT) | (ONE << AB_T100_BIT) |
        (ONE << AB_T10_FD_BIT)  | (ONE << AB_T10_BIT)  | (ONE << AB_SEL_BIT);

    localparam logic [DATA_W-1:0] PARTNER_BASE = ONE << AB_T100_BIT;

    localparam logic [DATA_W-1:0] PARTNER_LINK_BITS =
        (ONE << AB_T100_FD_BIT) | (ONE << AB_T10_FD_BIT) |
        (ONE << AB_T10_BIT)     | (ONE << AB_SEL_BIT);

    localparam logic [DATA_W-1:0] ABSENT_WORD = '1;

    typedef enum logic [2:0] {
        KIND_CTRL,
        KIND_STATUS,
        KIND_ID_HI,
        KIND_ID_LO,
        KIND_ADV,
        KIND_PARTNER,
        KIND_ZERO
    } reg_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] adv;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] partner;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } mgmt_state_t;

endpackage

// File: rtl/phy_req_decode.sv
module phy_req_decode
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned            PHY_ADDR_W = 5,
    parameter logic [PHY_ADDR_W-1:0]  PHY_ADDR   = '0
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [PHY_ADDR_W-1:0] req_phy,
    input  logic [IDX_W-1:0]      req_reg,
    output logic                  rd_req,
    output logic                  rd_match,
    output logic                  wr_ctrl,
    output logic                  wr_adv,
    output reg_kind_e             kind
);

    logic addr_hit;

    always_comb begin
        addr_hit = (req_phy == PHY_ADDR);
        rd_req   = req_valid && !req_write;
        rd_match = addr_hit;

        unique case (req_reg)
            IDX_CTRL:    kind = KIND_CTRL;
            IDX_STATUS:  kind = KIND_STATUS;
            IDX_ID_HI:   kind = KIND_ID_HI;
            IDX_ID_LO:   kind = KIND_ID_LO;
            IDX_ADV:     kind = KIND_ADV;
            IDX_PARTNER: kind = KIND_PARTNER;
            default:     kind = KIND_ZERO;
        endcase

        wr_ctrl = req_valid && req_write && addr_hit && (kind == KIND_CTRL);
        wr_adv  = req_valid && req_write && addr_hit && (kind == KIND_ADV);
    end

endmodule

// File: rtl/phy_link_bits.sv
module phy_link_bits
    import phy_mgmt_pkg::*;
(
    input  logic              link_up,
    output logic [DATA_W-1:0] status_next,
    output logic [DATA_W-1:0] partner_next
);

    always_comb begin
        status_next  = STATUS_BASE;
        partner_next = PARTNER_BASE;
        if (link_up) begin
            status_next  = status_next  | STATUS_LINK_BITS;
            partner_next = partner_next | PARTNER_LINK_BITS;
        end
    end

endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_mgmt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_HI = 16'h2C3A,
    parameter logic [DATA_W-1:0] ID_LO = 16'h71B0
) (
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] adv,
    input  logic [DATA_W-1:0] partner,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (kind)
            KIND_CTRL:    rdata = ctrl;
            KIND_STATUS:  rdata = status;
            KIND_ID_HI:   rdata = ID_HI;
            KIND_ID_LO:   rdata = ID_LO;
            KIND_ADV:     rdata = adv;
            KIND_PARTNER: rdata = partner;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned            PHY_ADDR_W = 5,
    parameter logic [PHY_ADDR_W-1:0]  PHY_ADDR   = 5'd1,
    parameter logic [DATA_W-1:0]      ID_HI      = 16'h2C3A,
    parameter logic [DATA_W-1:0]      ID_LO      = 16'h71B0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [PHY_ADDR_W-1:0] req_phy,
    input  logic [IDX_W-1:0]      req_reg,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  link_up,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata
);

    mgmt_state_t state_d, state_q;

    logic              rd_req;
    logic              rd_match;
    logic              wr_ctrl;
    logic              wr_adv;
    reg_kind_e         kind;
    logic [DATA_W-1:0] status_next;
    logic [DATA_W-1:0] partner_next;
    logic [DATA_W-1:0] mux_data;

    phy_req_decode #(
        .PHY_ADDR_W (PHY_ADDR_W),
        .PHY_ADDR   (PHY_ADDR)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .rd_req    (rd_req),
        .rd_match  (rd_match),
        .wr_ctrl   (wr_ctrl),
        .wr_adv    (wr_adv),
        .kind      (kind)
    );

    phy_link_bits u_link (
        .link_up      (link_up),
        .status_next  (status_next),
        .partner_next (partner_next)
    );

    phy_read_mux #(
        .ID_HI (ID_HI),
        .ID_LO (ID_LO)
    ) u_mux (
        .kind    (kind),
        .ctrl    (state_q.ctrl),
        .status  (state_q.status),
        .adv     (state_q.adv),
        .partner (state_q.partner),
        .rdata   (mux_data)
    );

    always_comb begin
        state_d = state_q;

        // response path: present data only in the cycle after a read
        state_d.rsp_valid = rd_req;
        if (!rd_req) begin
            state_d.rsp_data = '0;
        end else if (rd_match) begin
            state_d.rsp_data = mux_data;
        end else begin
            state_d.rsp_data = ABSENT_WORD;
        end

        // link-dependent words follow the live input every clock
        state_d.status  = status_next;
        state_d.partner = partner_next;

        if (wr_ctrl) begin
            if (req_wdata[CTRL_RST_BIT]) begin
                state_d.ctrl = CTRL_INIT;
                state_d.adv  = ADV_INIT;
            end else begin
                state_d.ctrl = req_wdata;
            end
        end

        if (wr_adv) begin
            state_d.adv = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl      <= CTRL_INIT;
            state_q.adv       <= ADV_INIT;
            state_q.status    <= STATUS_BASE;
            state_q.partner   <= PARTNER_BASE;
            state_q.rsp_valid <= 1'b0;
            state_q.rsp_data  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_rdata = state_q.rsp_data;

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
    parameter int unsigned           PHY_ADDR_W = 5,
    parameter logic [PHY_ADDR_W-1:0] PHY_ADDR   = 5'd1,
    parameter logic [15:0]           ID_HI      = 16'h2C3A
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [PHY_ADDR_W-1:0] req_phy,
    input logic [4:0]            req_reg,
    input logic [15:0]           req_wdata,
    input logic                  link_up,
    input logic                  rsp_valid,
    input logic [15:0]           rsp_rdata,
    input logic [15:0]           ctrl_q,
    input logic [15:0]           adv_q,
    input logic [15:0]           status_q,
    input logic [15:0]           partner_q
);

    logic own_ctrl_wr;
    assign own_ctrl_wr = req_valid && req_write && (req_phy == PHY_ADDR) && (req_reg == 5'd0);

    assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rsp_valid && rsp_rdata == 16'h0000));

    assert_absent_phy_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_phy != PHY_ADDR) |=> rsp_rdata == 16'hFFFF);

    assert_link_up_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> (status_q[2] && status_q[5] && partner_q == 16'h01E1));

    assert_link_down_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!status_q[2] && !status_q[5] && partner_q == 16'h0080));

    assert_ctrl_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_ctrl_wr && !req_wdata[15]) |=> ctrl_q == $past(req_wdata));

    assert_ctrl_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_ctrl_wr && req_wdata[15]) |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1));

    assert_id_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_phy == PHY_ADDR && req_reg == 5'd2) |=> rsp_rdata == ID_HI);

endmodule

bind phy_mgmt_regs phy_mgmt_checker #(
    .PHY_ADDR_W (PHY_ADDR_W),
    .PHY_ADDR   (PHY_ADDR),
    .ID_HI      (ID_HI)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .link_up   (link_up),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctrl_q    (state_q.ctrl),
    .adv_q     (state_q.adv),
    .status_q  (state_q.status),
    .partner_q (state_q.partner)
);

// File: tb/tb_phy_mgmt_regs.sv
module tb_phy_mgmt_regs;

    localparam logic [4:0]  MY_PHY = 5'd1;
    localparam logic [15:0] ID_A   = 16'h2C3A;
    localparam logic [15:0] ID_B   = 16'h71B0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        link_up = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_ctrl = 'h3100;
    int m_adv  = 'h01E1;
    bit m_link = 1'b0;

    phy_mgmt_regs #(
        .PHY_ADDR_W (5),
        .PHY_ADDR   (MY_PHY),
        .ID_HI      (ID_A),
        .ID_LO      (ID_B)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .link_up   (link_up),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    always #10 clk = ~clk;

    function automatic int model_word(input int idx);
        int w;
        case (idx)
            0: w = m_ctrl;
            1: w = m_link ? 'h786C : 'h7848;
            2: w = ID_A;
            3: w = ID_B;
            4: w = m_adv;
            5: w = m_link ? 'h01E1 : 'h0080;
            default: w = 0;
        endcase
        return w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // one clock: drive after a falling edge, model the rising edge, compare after the next falling edge
    task automatic step(input bit v, input bit w, input logic [4:0] phy,
                        input logic [4:0] idx, input logic [15:0] d, input string tag);
        int exp_v;
        int exp_d;
        req_valid = v;
        req_write = w;
        req_phy   = phy;
        req_reg   = idx;
        req_wdata = d;
        exp_v = (v && !w) ? 1 : 0;
        exp_d = 0;
        if (exp_v == 1) exp_d = (phy == MY_PHY) ? model_word(int'(idx)) : 'hFFFF;
        if (v && w && phy == MY_PHY) begin
            if (idx == 5'd0) begin
                if (d[15]) begin
                    m_ctrl = 'h3100;
                    m_adv  = 'h01E1;
                end else begin
                    m_ctrl = int'(d);
                end
            end else if (idx == 5'd4) begin
                m_adv = int'(d);
            end
        end
        m_link = link_up;
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, int'(rsp_valid), exp_v);
        check({tag, " data"}, int'(rsp_rdata), exp_d);
    endtask

    task automatic rd(input logic [4:0] idx, input string tag);
        step(1'b1, 1'b0, MY_PHY, idx, 16'h0000, tag);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [15:0] d, input string tag);
        step(1'b1, 1'b1, MY_PHY, idx, d, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, MY_PHY, 5'd0, 16'h0000, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0x0000 expected 0x0001");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(rsp_valid), 0);
        check("R1 reset data", int'(rsp_rdata), 0);
        rst_n = 1'b1;

        // R1 defaults, R10 identifiers
        rd(5'd0, "R1 ctrl");
        rd(5'd1, "R1 status");
        rd(5'd4, "R1 adv");
        rd(5'd5, "R1 partner");
        rd(5'd2, "R10 id hi");
        rd(5'd3, "R10 id lo");

        // R11 zero reads
        rd(5'd6, "R11 expansion");
        for (int i = 16; i <= 20; i++) rd(5'(i), "R11 vendor");
        rd(5'd7, "R11 undefined 7");
        rd(5'd31, "R11 undefined 31");

        // R3 absent PHY
        step(1'b1, 1'b0, 5'd0, 5'd0, 16'h0, "R3 foreign read 0");
        step(1'b1, 1'b0, 5'd31, 5'd1, 16'h0, "R3 foreign read 31");
        step(1'b1, 1'b1, 5'd2, 5'd0, 16'h0000, "R3 foreign ctrl write");
        step(1'b1, 1'b1, 5'd2, 5'd4, 16'h0000, "R3 foreign adv write");
        rd(5'd0, "R3 ctrl kept");
        rd(5'd4, "R3 adv kept");

        // R4 link up, R5 link down
        link_up = 1'b1;
        rd(5'd1, "R4 status same cycle");
        rd(5'd1, "R4 status");
        rd(5'd5, "R4 partner");
        link_up = 1'b0;
        idle("R5 settle");
        rd(5'd1, "R5 status");
        rd(5'd5, "R5 partner");

        // R6 control store
        wr(5'd0, 16'h0100, "R6 write");
        rd(5'd0, "R6 ctrl");
        wr(5'd0, 16'h7FFF, "R6 write all");
        rd(5'd0, "R6 ctrl all");

        // R8 advertisement
        wr(5'd4, 16'h0061, "R8 write");
        rd(5'd4, "R8 adv");
        wr(5'd4, 16'hFFFF, "R8 write ones");
        rd(5'd4, "R8 adv ones");

        // R9 read-only words
        wr(5'd1, 16'hAAAA, "R9 write status");
        wr(5'd2, 16'hAAAA, "R9 write id hi");
        wr(5'd3, 16'hAAAA, "R9 write id lo");
        wr(5'd5, 16'hAAAA, "R9 write partner");
        wr(5'd6, 16'hAAAA, "R9 write expansion");
        rd(5'd1, "R9 status");
        rd(5'd2, "R9 id hi");
        rd(5'd3, "R9 id lo");
        rd(5'd5, "R9 partner");
        rd(5'd6, "R9 expansion");

        // R7 control reset with link up
        link_up = 1'b1;
        wr(5'd0, 16'h8000, "R7 reset write");
        rd(5'd0, "R7 ctrl");
        rd(5'd4, "R7 adv");
        rd(5'd1, "R7 status");
        rd(5'd5, "R7 partner");

        // R2 back-to-back reads and gaps
        rd(5'd2, "R2 burst a");
        rd(5'd3, "R2 burst b");
        wr(5'd4, 16'h01E1, "R2 write no rsp");
        idle("R2 idle");
        rd(5'd4, "R2 after gap");
        idle("R2 trailing");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule